// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is an 8-bit control register with a small sequencer behind it that manages the power modes of a microcontroller core. Software writes one byte. Single bits in that byte request stop, sleep or time-base-timer mode. Another bit sets whether the external pins float or keep their level while the core is in a deep mode. A further bit fires a software internal reset. A two-bit field sets how long the CPU clock pauses after every instruction.

Most bits are action triggers and do not store a value. A mode request stays active until an interrupt request withdraws it. The reset trigger produces a pulse that lasts a fixed number of machine cycles. When the pulse ends, the register returns to its defaults. The clock-pause field loads a down-counter on each instruction-complete strobe. The CPU clock enable stays low until that counter empties.

The block runs on the CPU clock `clk`. The machine cycle is marked by the clock enable `mcyc_en`.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset all mode requests are low, `pins_hiz` and `int_rst` are low, `cpu_clk_en` is high and `rd_data` reads 8'h18.
- R2: A write with bit 7 set raises `stop_req` on the next clock. It stays high until an interrupt request or the end of an internal reset pulse.
- R3: A write with bit 6 set, and without a higher-priority request, raises `sleep_req`. A write with bit 7 clear, bit 6 clear and bit 3 set leaves the active mode unchanged.
- R4: A write with bit 3 clear enters time-base-timer mode (`tbt_req`) only when `clk_mode` is 2'b01 (main) or 2'b10 (PLL). With 2'b00 or 2'b11 that request is ignored.
- R5: When one write requests several modes, stop wins over time-base-timer, and time-base-timer wins over sleep. At most one mode request is high at any time.
- R6: `irq` high at a clock edge clears any mode request on the next clock. It also wins over a mode request written in the same cycle. Bits 5 and 2:1 are still stored by that write.
- R7: `rd_data` always reads 0 on bits 7, 6 and 0 and 1 on bits 4 and 3. Bit 5 and bits 2:1 read back the stored values.
- R8: `pins_hiz` is high exactly when the stored bit 5 is 1 and stop or time-base-timer mode is active. It is never high in sleep mode.
- R9: A write with bit 4 clear raises `int_rst` for exactly RST_CYCLES (default 3) clocks on which `mcyc_en` is high. Any write made while `int_rst` is high is ignored.
- R10: When the internal reset pulse ends, the mode returns to run, bits 5 and 2:1 return to 0, and any clock pause in progress is cancelled.
- R11: On `insn_done`, `cpu_clk_en` goes low from the next clock. It stays low for 8, 16 or 32 clocks when bits 2:1 are 01, 10 or 11. A new `insn_done` reloads the count.
- R12: With bits 2:1 at 00, `insn_done` does not lower `cpu_clk_en`, and it cancels any pause still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcyc_en | input | 1 | Machine-cycle clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq | input | 1 | Interrupt request (wake-up) |
| insn_done | input | 1 | Instruction-complete strobe |
| clk_mode | input | 2 | Current clock source: 01 main, 10 PLL, others slow |
| stop_req | output | 1 | Stop mode request |
| sleep_req | output | 1 | Sleep mode request |
| tbt_req | output | 1 | Time-base-timer mode request |
| pins_hiz | output | 1 | External pins to high impedance |
| int_rst | output | 1 | Internal reset pulse |
| cpu_clk_en | output | 1 | CPU clock enable |

## Verification
The hardest case to reach is the internal reset pulse with sparse machine-cycle enables. Writes arrive during the pulse, and the defaults must be restored at its last edge while a mode and a clock pause are both active. The stimulus first places the block in stop mode with a long pause running. It then fires the reset while `mcyc_en` toggles, and it writes a stop request in the middle of the pulse. A randomised phase then mixes rare reset triggers with interrupts and instruction strobes. Throughout, a behavioural model checks every output on every clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_RUN   = 2'd0,
    LPM_STOP  = 2'd1,
    LPM_TBT   = 2'd2,
    LPM_SLEEP = 2'd3
  } lpm_mode_e;

  localparam int unsigned B_STOP   = 7;
  localparam int unsigned B_SLEEP  = 6;
  localparam int unsigned B_PINZ   = 5;
  localparam int unsigned B_SWRST  = 4;
  localparam int unsigned B_TBT    = 3;
  localparam int unsigned B_HSELHI = 2;
  localparam int unsigned B_HSELLO = 1;

  localparam logic [1:0] CLK_MAIN = 2'b01;
  localparam logic [1:0] CLK_PLL  = 2'b10;
endpackage

// File: rtl/lpm_mode_ctl.sv
module lpm_mode_ctl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [7:0] wr_data,
  input  logic [1:0] clk_mode,
  input  logic       irq,
  input  logic       soft_clr,
  output lpm_mode_e  mode,
  output logic       pin_sel
);
  lpm_mode_e mode_d;
  logic      pin_d;
  logic      clk_ok;
  logic      req_stop, req_tbt, req_sleep;

  assign clk_ok    = (clk_mode == CLK_MAIN) || (clk_mode == CLK_PLL);
  assign req_stop  = wr_data[B_STOP];
  assign req_tbt   = !wr_data[B_TBT] && clk_ok;
  assign req_sleep = wr_data[B_SLEEP];

  always_comb begin
    mode_d = mode;
    pin_d  = pin_sel;
    if (soft_clr) begin
      mode_d = LPM_RUN;
      pin_d  = 1'b0;
    end else begin
      if (wr_ok) pin_d = wr_data[B_PINZ];
      if (irq) begin
        mode_d = LPM_RUN;
      end else if (wr_ok) begin
        if (req_stop)       mode_d = LPM_STOP;
        else if (req_tbt)   mode_d = LPM_TBT;
        else if (req_sleep) mode_d = LPM_SLEEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= LPM_RUN;
      pin_sel <= 1'b0;
    end else begin
      mode    <= mode_d;
      pin_sel <= pin_d;
    end
  end

  a_r6_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (mode == LPM_RUN));
  a_r4_tbt_clk_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LPM_TBT) && ($past(mode) != LPM_TBT) |-> $past(clk_ok));
  a_r10_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (mode == LPM_RUN) && !pin_sel);
endmodule

// File: rtl/lpm_rst_pulse.sv
module lpm_rst_pulse #(
  parameter int unsigned RST_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mcyc_en,
  input  logic trig,
  output logic busy,
  output logic soft_clr
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt, cnt_d;

  assign busy     = (cnt != '0);
  assign soft_clr = mcyc_en && (cnt == CW'(1));

  always_comb begin
    cnt_d = cnt;
    if (busy) begin
      if (mcyc_en) cnt_d = cnt - CW'(1);
    end else if (trig) begin
      cnt_d = LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mcyc_en |=> busy);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD);
  a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && trig |=> busy);
endmodule

// File: rtl/lpm_halt_gate.sv
module lpm_halt_gate #(
  parameter int unsigned HALT_BASE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic [1:0] wr_sel,
  input  logic       soft_clr,
  input  logic       insn_done,
  output logic [1:0] sel,
  output logic       cpu_clk_en
);
  localparam int unsigned MAXLEN = HALT_BASE * 4;
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] cnt, cnt_d, len;
  logic [1:0]    sel_d;

  always_comb begin
    case (sel)
      2'b01:   len = CW'(HALT_BASE);
      2'b10:   len = CW'(HALT_BASE * 2);
      2'b11:   len = CW'(HALT_BASE * 4);
      default: len = '0;
    endcase
  end

  always_comb begin
    sel_d = sel;
    cnt_d = cnt;
    if (soft_clr) begin
      sel_d = 2'b00;
      cnt_d = '0;
    end else begin
      if (wr_ok) sel_d = wr_sel;
      if (insn_done)        cnt_d = len;
      else if (cnt != '0)   cnt_d = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 2'b00;
      cnt <= '0;
    end else begin
      sel <= sel_d;
      cnt <= cnt_d;
    end
  end

  assign cpu_clk_en = (cnt == '0);

  a_r11_pause_starts: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done && !soft_clr && (sel != 2'b00) |=> !cpu_clk_en);
  a_r12_no_pause: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done && (sel == 2'b00) |=> cpu_clk_en);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 3,
  parameter int unsigned HALT_BASE  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mcyc_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq,
  input  logic       insn_done,
  input  logic [1:0] clk_mode,
  output logic       stop_req,
  output logic       sleep_req,
  output logic       tbt_req,
  output logic       pins_hiz,
  output logic       int_rst,
  output logic       cpu_clk_en
);
  lpm_mode_e  mode;
  logic       pin_sel, busy, soft_clr, wr_ok;
  logic [1:0] sel;

  assign wr_ok = wr_en && !busy;

  lpm_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .mcyc_en(mcyc_en),
    .trig(wr_ok && !wr_data[B_SWRST]),
    .busy(busy), .soft_clr(soft_clr)
  );

  lpm_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_data(wr_data),
    .clk_mode(clk_mode), .irq(irq), .soft_clr(soft_clr),
    .mode(mode), .pin_sel(pin_sel)
  );

  lpm_halt_gate #(.HALT_BASE(HALT_BASE)) u_halt (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
    .wr_sel(wr_data[B_HSELHI:B_HSELLO]), .soft_clr(soft_clr),
    .insn_done(insn_done), .sel(sel), .cpu_clk_en(cpu_clk_en)
  );

  assign stop_req  = (mode == LPM_STOP);
  assign sleep_req = (mode == LPM_SLEEP);
  assign tbt_req   = (mode == LPM_TBT);
  assign pins_hiz  = pin_sel && (stop_req || tbt_req);
  assign int_rst   = busy;
  assign rd_data   = {2'b00, pin_sel, 2'b11, sel, 1'b0};

  a_r5_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop_req, sleep_req, tbt_req}));
  a_r8_sleep_drives: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> !pins_hiz);
  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst && wr_en && !mcyc_en && !irq |=> $stable(rd_data) && $stable(stop_req));
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mcyc_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h18;
  logic       irq = 1'b0;
  logic       insn_done = 1'b0;
  logic [1:0] clk_mode = 2'b01;
  logic [7:0] rd_data;
  logic       stop_req, sleep_req, tbt_req, pins_hiz, int_rst, cpu_clk_en;

  int checks = 0;
  int fails  = 0;
  int wdog   = 0;

  always #4 clk = ~clk;

  lpm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mcyc_en(mcyc_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .insn_done(insn_done),
    .clk_mode(clk_mode), .stop_req(stop_req), .sleep_req(sleep_req),
    .tbt_req(tbt_req), .pins_hiz(pins_hiz), .int_rst(int_rst),
    .cpu_clk_en(cpu_clk_en)
  );

  // Behavioural reference: 0 run, 1 stop, 2 time-base timer, 3 sleep
  int m_mode = 0, m_pin = 0, m_sel = 0, m_rst_left = 0, m_pause = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pin = 0; m_sel = 0; m_rst_left = 0; m_pause = 0;
    end else begin
      bit accept, ending;
      accept = wr_en && (m_rst_left == 0);
      ending = (m_rst_left == 1) && mcyc_en;
      if (m_rst_left > 0) begin
        if (mcyc_en) m_rst_left--;
      end else if (accept && !wr_data[4]) m_rst_left = 3;
      if (insn_done) m_pause = (m_sel == 0) ? 0 : 8 * (1 << (m_sel - 1));
      else if (m_pause > 0) m_pause--;
      if (accept) begin
        m_pin = wr_data[5];
        m_sel = wr_data[2:1];
        if (wr_data[7]) m_mode = 1;
        else if (!wr_data[3] && (clk_mode == 2'b01 || clk_mode == 2'b10)) m_mode = 2;
        else if (wr_data[6]) m_mode = 3;
      end
      if (irq) m_mode = 0;
      if (ending) begin
        m_mode = 0; m_pin = 0; m_sel = 0; m_pause = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "stop_req", int'(stop_req), int'(m_mode == 1));
      chk("R3", "sleep_req", int'(sleep_req), int'(m_mode == 3));
      chk("R4", "tbt_req", int'(tbt_req), int'(m_mode == 2));
      chk("R8", "pins_hiz", int'(pins_hiz), int'(m_pin == 1 && (m_mode == 1 || m_mode == 2)));
      chk("R9", "int_rst", int'(int_rst), int'(m_rst_left != 0));
      chk("R11", "cpu_clk_en", int'(cpu_clk_en), int'(m_pause == 0));
      chk("R7", "rd_data", int'(rd_data), (m_pin << 5) | 8'h18 | (m_sel << 1));
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h18;
  endtask

  task automatic pulse_irq();
    irq = 1'b1; @(negedge clk); irq = 1'b0;
  endtask

  task automatic step_insn(input int gap);
    insn_done = 1'b1; @(negedge clk); insn_done = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", wdog);
      finish_run();
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: defaults after reset
    chk("R1", "rd_data reset", int'(rd_data), 8'h18);
    chk("R1", "modes reset", int'({stop_req, sleep_req, tbt_req, pins_hiz, int_rst}), 0);
    chk("R1", "cpu_clk_en reset", int'(cpu_clk_en), 1);

    // R11/R12: pause lengths and reload
    wr(8'h1A); step_insn(12);
    wr(8'h1C); step_insn(20);
    wr(8'h1E); step_insn(5); step_insn(40);
    step_insn(3);
    wr(8'h18); step_insn(4); // R12 cancels running pause

    // R2/R8: stop with and without floating pins
    wr(8'h98); repeat (3) @(negedge clk); pulse_irq();
    wr(8'hB8); repeat (3) @(negedge clk); pulse_irq();
    // R3/R8: sleep never floats pins; neutral write keeps mode
    wr(8'h78); wr(8'h18); repeat (2) @(negedge clk); pulse_irq();
    // R4: clock-mode gate for time-base timer
    clk_mode = 2'b01; wr(8'h30); pulse_irq();
    clk_mode = 2'b00; wr(8'h30); @(negedge clk);
    clk_mode = 2'b11; wr(8'h30); @(negedge clk);
    clk_mode = 2'b10; wr(8'h30); pulse_irq();
    // R5: priority
    wr(8'hD0); pulse_irq();
    wr(8'h50); pulse_irq();
    clk_mode = 2'b00; wr(8'h50); pulse_irq();
    clk_mode = 2'b01;
    // R6: irq beats a same-cycle write
    irq = 1'b1; wr(8'hBE); irq = 1'b0; @(negedge clk);
    chk("R6", "stop after irq+write", int'(stop_req), 0);
    chk("R6", "fields kept", int'(rd_data), 8'h3E);

    // R9/R10: reset pulse with sparse machine cycles during stop + pause
    wr(8'hBE); step_insn(2);
    mcyc_en = 1'b0;
    wr(8'hA8);
    wr(8'h98); // ignored while pulse active (R9)
    for (int i = 0; i < 10; i++) begin
      mcyc_en = (i % 2 == 1); @(negedge clk);
    end
    mcyc_en = 1'b1; @(negedge clk);
    chk("R10", "defaults after pulse", int'(rd_data), 8'h18);
    chk("R10", "pause cancelled", int'(cpu_clk_en), 1);
    // R9: pulse length with every cycle a machine cycle
    hi = 0;
    wr_en = 1'b1; wr_data = 8'h08; @(negedge clk); wr_en = 1'b0; wr_data = 8'h18;
    for (int i = 0; i < 8; i++) begin
      if (int_rst) hi++;
      @(negedge clk);
    end
    chk("R9", "pulse length", hi, 3);

    // mixed random phase
    for (int i = 0; i < 600; i++) begin
      wr_en     = ($urandom_range(0, 3) == 0);
      wr_data   = 8'($urandom) | 8'h10;
      if ($urandom_range(0, 15) == 0) wr_data[4] = 1'b0;
      wr_data[0] = 1'b0;
      irq       = ($urandom_range(0, 7) == 0);
      insn_done = ($urandom_range(0, 9) == 0);
      mcyc_en   = ($urandom_range(0, 2) != 0);
      clk_mode  = 2'($urandom);
      @(negedge clk);
    end
    wr_en = 1'b0; irq = 1'b0; insn_done = 1'b0; mcyc_en = 1'b1;
    repeat (40) @(negedge clk);
    finish_run();
  end
endmodule